// File: doc/BRIEF.md
# Serial Configuration Target for an Audio/Video Switch

This block is the two-wire serial control port of a video and audio source switch. It runs on a fast system clock. It resynchronises and debounces the serial clock and data lines, finds START and STOP conditions, and answers one 7-bit address. A strap input selects which of two addresses that is. The port holds four 8-bit configuration registers, and their contents go straight to the switch and gain logic.

Write transactions carry no register pointer. The first data byte after the address always lands in register 0, and each byte after it goes to the next register. A controller that wants to change a high register must therefore resend the lower ones. A read returns one fixed identification byte. A general-call write carrying the reset code returns every register to zero. The data line is only ever pulled low. The block drives a pull-down enable, and an external open-drain stage turns it into the bus level.

Top module: `avsw_cfg_target`

## Requirements
- R1: While `rstN` is low, and after it is released, `cfgRegs` reads all zeros and `sdaPullEn` is 0.
- R2: The target answers address 7'b1001000 when `addrStrap` is 1 and 7'b1010000 when it is 0. For a matching address it pulls SDA low during the ninth clock. For any other address (except the general call) it leaves SDA released and the registers unchanged.
- R3: In a write (R/W bit 0, the eighth bit after START), each data byte is shifted in MSB first on rising SCL and is acknowledged. Byte k of the transaction (k = 0..3) is stored in register k, which appears at `cfgRegs[8k+7:8k]`.
- R4: Data bytes after the fourth are acknowledged, and every register keeps its value.
- R5: In a read (R/W bit 1), the target sends 8'h20 MSB first, one bit per SCL clock, and releases SDA before the master's acknowledge clock.
- R6: A write to address 7'b0000000 is acknowledged. If its first data byte is 8'h06, all registers clear to zero. Any other value leaves the registers unchanged, and general-call bytes are never stored.
- R7: A repeated START begins a new address phase, and the next data byte goes to register 0 again. A STOP releases SDA and ends the transaction.
- R8: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks (default 12, i.e. 60 ns at 200 MHz) has no effect. This includes an SDA pulse while SCL is high, which would otherwise look like START or STOP.
- R9: `sdaPullEn` changes only while SCL is low.
- R10: Register 3 is written only as the fourth byte of a transaction, after register 2. A three-byte write leaves register 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| addrStrap | input | 1 | Address select: 1 (or pulled up) selects 1001000, 0 selects 1010000 |
| sdaPullEn | output | 1 | When 1, the open-drain stage pulls SDA low |
| cfgRegs | output | 32 | Register k at bits [8k+7:8k] |

## Verification
The bench looks for an address decoder that answers the wrong strap value, or that acknowledges foreign addresses and so takes over the bus for another target. It sends more than four bytes: a pointer that wraps or is not bounded would overwrite register 0 or 3. It injects short pulses on both lines. A weak filter would count an extra clock and shift every later bit, or would see a false START or STOP in the middle of a byte. It also checks a general call with a non-reset code, a repeated START, and a three-byte write. A design that got these wrong would clear the registers, keep writing from the old register index, or touch register 3.

// File: rtl/avsw_pkg.sv
`timescale 1ns/1ps
package avsw_pkg;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = 8;
  localparam logic [6:0] ADDR_STRAP_HI = 7'b1001000;
  localparam logic [6:0] ADDR_STRAP_LO = 7'b1010000;
  localparam logic [7:0] ID_BYTE       = 8'h20;
  localparam logic [7:0] GC_RESET_CODE = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_DONE
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic clearTxn;
    logic commitByte;
    logic gcReset;
    logic loadTx;
    logic shiftTx;
  } avswStrobes_t;
endpackage

// File: rtl/avsw_line_filter.sv
`timescale 1ns/1ps
module avsw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncd;
  logic [CNT_W-1:0]       stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end
  assign syncd = syncQ[SYNC_STAGES-1];

  // Output follows only after FILT_CYCLES consecutive disagreeing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOut   <= 1'b1;
      stableCnt <= '0;
    end else if (syncd == lineOut) begin
      stableCnt <= '0;
    end else if (stableCnt == CNT_LAST) begin
      lineOut   <= syncd;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // R8: a change of the filtered line always moves toward the synchronised input
  p_follow_sync_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineOut) |-> lineOut == $past(syncd));
endmodule

// File: rtl/avsw_reg_dp.sv
`timescale 1ns/1ps
module avsw_reg_dp
  import avsw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  avswStrobes_t              stb,
  input  logic                      rxBit,
  output logic [REG_W-1:0]          rxByte,
  output logic                      txMsb,
  output logic [NUM_REGS*REG_W-1:0] regsOut
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

  logic [REG_W-1:0] rxShift;
  logic [REG_W-1:0] txShift;
  logic [IDX_W-1:0] byteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.shiftRx) rxShift <= {rxShift[REG_W-2:0], rxBit};
  end
  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= '0;
    else if (stb.loadTx)  txShift <= ID_BYTE;
    else if (stb.shiftTx) txShift <= {txShift[REG_W-2:0], 1'b0};
  end
  assign txMsb = txShift[REG_W-1];

  // Byte index saturates one past the last register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   byteIdx <= '0;
    else if (stb.clearTxn)                       byteIdx <= '0;
    else if (stb.commitByte && byteIdx != IDX_END) byteIdx <= byteIdx + 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            q <= '0;
      else if (stb.gcReset) q <= '0;
      else if (stb.commitByte && byteIdx == IDX_W'(g)) q <= rxShift;
    end
    assign regsOut[g*REG_W +: REG_W] = q;
  end

  // R4: index never runs past the saturation value
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx <= IDX_END);
  // R6: general-call reset clears the whole file
  p_gc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.gcReset |=> regsOut == '0);
  // R3: registers move only on a committed byte or a reset code
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commitByte || stb.gcReset) |=> $stable(regsOut));
  // R4: a saturated index leaves the registers unchanged on commit
  p_overflow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitByte && byteIdx == IDX_END && !stb.gcReset) |=> $stable(regsOut));
endmodule

// File: rtl/avsw_i2c_ctrl.sv
`timescale 1ns/1ps
module avsw_i2c_ctrl
  import avsw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclF,
  input  logic         sdaF,
  input  logic         addrStrap,
  input  logic [7:0]   rxByte,
  input  logic         txMsb,
  output avswStrobes_t stb,
  output logic         sdaPull
);
  ctrlState_t state;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic       isRead, isGc, gcFirst;

  logic sclRise, sclFall, startDet, stopDet;
  logic [6:0] myAddr;
  logic addrHit, gcHit, byteEnd;

  assign sclRise  = ~sclPrev & sclF;
  assign sclFall  = sclPrev & ~sclF;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign myAddr   = addrStrap ? ADDR_STRAP_HI : ADDR_STRAP_LO;
  assign addrHit  = (rxByte[7:1] == myAddr);
  assign gcHit    = (rxByte == 8'h00);
  assign byteEnd  = sclFall && (bitCnt == 4'd8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  always_comb begin
    stb            = '0;
    stb.clearTxn   = startDet;
    stb.shiftRx    = sclRise && (state == ST_ADDR || state == ST_WR);
    stb.commitByte = !startDet && !stopDet && state == ST_WR && byteEnd && !isGc;
    stb.gcReset    = !startDet && !stopDet && state == ST_WR && byteEnd && isGc &&
                     gcFirst && (rxByte == GC_RESET_CODE);
    stb.loadTx     = state == ST_ADDR && byteEnd && addrHit && rxByte[0];
    stb.shiftTx    = (state == ST_ADDR_ACK && sclFall && isRead) ||
                     (state == ST_RD && sclFall && bitCnt != 4'd8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      sdaPull <= 1'b0;
      isRead  <= 1'b0;
      isGc    <= 1'b0;
      gcFirst <= 1'b0;
    end else if (startDet) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      sdaPull <= 1'b0;
      isGc    <= 1'b0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
      sdaPull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            if (addrHit) begin
              sdaPull <= 1'b1;
              isRead  <= rxByte[0];
              isGc    <= 1'b0;
              state   <= ST_ADDR_ACK;
            end else if (gcHit) begin
              sdaPull <= 1'b1;
              isRead  <= 1'b0;
              isGc    <= 1'b1;
              gcFirst <= 1'b1;
              state   <= ST_ADDR_ACK;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              sdaPull <= ~txMsb;
              state   <= ST_RD;
            end else begin
              sdaPull <= 1'b0;
              state   <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            sdaPull <= 1'b1;
            gcFirst <= 1'b0;
            state   <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            sdaPull <= 1'b0;
            bitCnt  <= '0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaPull <= 1'b0;
              state   <= ST_DONE;
            end else begin
              sdaPull <= ~txMsb;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9: the pull-down never moves while filtered SCL stays high
  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && sclPrev) |-> $stable(sdaPull));
  // R2: a foreign, non-general-call address is never acknowledged
  p_nack_foreign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteEnd && !addrHit && !gcHit && !startDet && !stopDet)
      |=> !sdaPull);
  // R7: STOP returns the port to idle with SDA released
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !sdaPull));
  // R3: every received data byte is acknowledged
  p_data_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WR_ACK |-> sdaPull);
endmodule

// File: rtl/avsw_cfg_target.sv
`timescale 1ns/1ps
module avsw_cfg_target
  import avsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic                      addrStrap,
  output logic                      sdaPullEn,
  output logic [NUM_REGS*REG_W-1:0] cfgRegs
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] lineRaw, lineFilt;
  avswStrobes_t         stb;
  logic [REG_W-1:0]     rxByte;
  logic                 txMsb;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    avsw_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (lineRaw[g]),
      .lineOut(lineFilt[g])
    );
  end

  avsw_i2c_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (lineFilt[0]),
    .sdaF     (lineFilt[1]),
    .addrStrap(addrStrap),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .stb      (stb),
    .sdaPull  (sdaPullEn)
  );

  avsw_reg_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxBit  (lineFilt[1]),
    .rxByte (rxByte),
    .txMsb  (txMsb),
    .regsOut(cfgRegs)
  );
endmodule

// File: tb/avsw_cfg_target_tb.sv
`timescale 1ns/1ps
module avsw_cfg_target_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        addrStrap = 1'b1;
  logic        sdaPullEn;
  logic [31:0] cfgRegs;
  wire         sdaBus = sdaM & ~sdaPullEn;

  int checks = 0;
  int errors = 0;
  int r9Viol = 0;

  always #2.5 clk = ~clk;

  avsw_cfg_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrStrap(addrStrap), .sdaPullEn(sdaPullEn), .cfgRegs(cfgRegs)
  );

  typedef struct packed {
    logic [7:0]       addr;
    logic [2:0]       nBytes;
    logic [5:0][7:0]  data;
    logic             expAck;
    logic [31:0]      expRegs;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{8'h90, 3'd1, 48'h0000_0000_0011, 1'b1, 32'h0000_0011},
    '{8'h90, 3'd2, 48'h0000_0000_3322, 1'b1, 32'h0000_3322},
    '{8'h90, 3'd4, 48'h0000_7766_5544, 1'b1, 32'h7766_5544},
    '{8'h90, 3'd6, 48'h0605_0403_0201, 1'b1, 32'h0403_0201},
    '{8'hA0, 3'd1, 48'h0000_0000_00FF, 1'b0, 32'h0403_0201},
    '{8'h90, 3'd3, 48'h0000_000C_0B0A, 1'b1, 32'h040C_0B0A}
  };

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // SDA pull-down must not move while the raw SCL is high
  logic prevPull = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && (sdaPullEn !== prevPull)) r9Viol++;
    prevPull <= sdaPullEn;
  end

  task automatic busStart();
    sdaM = 1; sclM = 1; w(40);
    sdaM = 0; w(40);
    sclM = 0; w(20);
  endtask

  task automatic busRestart();
    sdaM = 1; w(20);
    sclM = 1; w(40);
    sdaM = 0; w(40);
    sclM = 0; w(20);
  endtask

  task automatic busStop();
    sdaM = 0; w(20);
    sclM = 1; w(40);
    sdaM = 1; w(40);
  endtask

  task automatic clockBit(input logic b, input logic glitch, output logic s);
    sdaM = b; w(20);
    sclM = 1; w(10);
    if (glitch) begin
      sdaM = ~b; w(5); sdaM = b; w(5);
    end else w(10);
    s = sdaBus; w(20);
    sclM = 0; w(20);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic [7:0] gMask,
                          output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], gMask[i], s);
    clockBit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic readByte(output logic [7:0] v, output logic released);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 1'b0, s);
      v[i] = s;
    end
    clockBit(1'b1, 1'b0, s);   // master NACK; target must have let go
    released = s;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic ack, ackAll, rel;
    logic [7:0] rd;

    w(10);
    chk(cfgRegs == 32'h0 && !sdaPullEn, "R1 in reset", {cfgRegs[30:0], sdaPullEn}, 32'h0);
    rstN = 1; w(20);
    chk(cfgRegs == 32'h0 && !sdaPullEn, "R1 after reset", {cfgRegs[30:0], sdaPullEn}, 32'h0);

    // Vector table: R2 R3 R4 R10
    for (int k = 0; k < NVEC; k++) begin
      busStart();
      sendByte(VEC[k].addr, 8'h00, ack);
      chk(ack == VEC[k].expAck, "R2 address ack", {31'd0, ack}, {31'd0, VEC[k].expAck});
      ackAll = 1'b1;
      if (ack) begin
        for (int j = 0; j < VEC[k].nBytes; j++) begin
          logic a;
          sendByte(VEC[k].data[j], 8'h00, a);
          ackAll &= a;
        end
        chk(ackAll, "R3/R4 data ack", {31'd0, ackAll}, 32'd1);
      end
      busStop(); w(40);
      chk(cfgRegs == VEC[k].expRegs, "R3/R4/R10 register file", cfgRegs, VEC[k].expRegs);
    end

    // R5: read returns the ID byte and releases SDA
    busStart();
    sendByte(8'h91, 8'h00, ack);
    chk(ack, "R5 read address ack", {31'd0, ack}, 32'd1);
    readByte(rd, rel);
    chk(rd == 8'h20, "R5 read byte", {24'd0, rd}, 32'h20);
    chk(rel, "R5 SDA released at master ack", {31'd0, rel}, 32'd1);
    busStop(); w(40);
    chk(cfgRegs == 32'h040C_0B0A, "R5 read leaves registers", cfgRegs, 32'h040C_0B0A);

    // R2: foreign read address is ignored
    busStart();
    sendByte(8'hA1, 8'h00, ack);
    chk(!ack, "R2 foreign read nack", {31'd0, ack}, 32'd0);
    busStop(); w(40);

    // R8: SCL pulse in a low phase and SDA pulses while SCL high
    busStart();
    sendByte(8'h90, 8'h00, ack);
    sclM = 1; w(5); sclM = 0; w(20);
    sendByte(8'h5A, 8'hFF, ack);
    chk(ack, "R8 data ack with glitches", {31'd0, ack}, 32'd1);
    busStop(); w(40);
    chk(cfgRegs == 32'h040C_0B5A, "R8 glitches ignored", cfgRegs, 32'h040C_0B5A);

    // R7: repeated START restarts at register 0
    busStart();
    sendByte(8'h90, 8'h00, ack);
    sendByte(8'hAA, 8'h00, ack);
    sendByte(8'hBB, 8'h00, ack);
    busRestart();
    sendByte(8'h90, 8'h00, ack);
    chk(ack, "R7 address after repeated START", {31'd0, ack}, 32'd1);
    sendByte(8'hCC, 8'h00, ack);
    busStop(); w(40);
    chk(cfgRegs == 32'h040C_BBCC, "R7 restart to register 0", cfgRegs, 32'h040C_BBCC);
    chk(!sdaPullEn, "R7 released after STOP", {31'd0, sdaPullEn}, 32'd0);

    // R6: general call with a non-reset code, then with the reset code
    busStart();
    sendByte(8'h00, 8'h00, ack);
    chk(ack, "R6 general call ack", {31'd0, ack}, 32'd1);
    sendByte(8'h05, 8'h00, ack);
    busStop(); w(40);
    chk(cfgRegs == 32'h040C_BBCC, "R6 other code no effect", cfgRegs, 32'h040C_BBCC);
    busStart();
    sendByte(8'h00, 8'h00, ack);
    sendByte(8'h06, 8'h00, ack);
    chk(ack, "R6 reset code ack", {31'd0, ack}, 32'd1);
    busStop(); w(40);
    chk(cfgRegs == 32'h0, "R6 reset code clears", cfgRegs, 32'h0);

    // R2: strap low selects the other address
    addrStrap = 1'b0; w(20);
    busStart();
    sendByte(8'hA0, 8'h00, ack);
    chk(ack, "R2 strap low address ack", {31'd0, ack}, 32'd1);
    sendByte(8'h12, 8'h00, ack);
    busStop(); w(40);
    chk(cfgRegs == 32'h0000_0012, "R2 strap low write", cfgRegs, 32'h12);
    busStart();
    sendByte(8'h90, 8'h00, ack);
    chk(!ack, "R2 strap low rejects high address", {31'd0, ack}, 32'd0);
    busStop(); w(40);
    chk(cfgRegs == 32'h0000_0012, "R2 no change on nack", cfgRegs, 32'h12);

    chk(r9Viol == 0, "R9 pull stable while SCL high", r9Viol, 32'd0);

    // R1: reset mid-run
    rstN = 1'b0; w(5);
    chk(cfgRegs == 32'h0 && !sdaPullEn, "R1 reset asserted again",
        {cfgRegs[30:0], sdaPullEn}, 32'h0);
    rstN = 1'b1; w(5);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule